// File: doc/BRIEF.md
# Packet-Committing Slave Write FIFO

This block accepts bytes from an external bus master on a synchronous interface and files them into one of several independent endpoint buffers, selected by a small address field. The bytes in each buffer are grouped into packets. A packet is closed in one of two ways. In automatic mode it closes when its word count reaches a programmed length. It can also be closed by a packet-end strobe from the master.

Each closed packet becomes a descriptor in a small committed-packet queue. A descriptor gives the packet length, the buffer index and the packet's start position in that buffer. A downstream consumer takes descriptors with a valid/ready handshake and reads the words through a simple random-access read port. Popping a descriptor returns that packet's space to its buffer.

Each buffer reports registered empty, full and programmable-level flags. Each buffer also has a sticky overflow bit that records refused writes and refused commits.

Top module: `slave_pkt_fifo`

## Requirements
- R1: A write takes place at a rising edge only when `cs_n` and `wr_n` are both low. A packet-end strobe is seen only when `cs_n` and `pktend_n` are both low. Any other combination changes no buffer and queues no descriptor.
- R2: While the write strobe stays low, one word is stored on every rising edge with no idle cycles. The write position of the buffer advances by one (modulo DEPTH) for each stored word. Word k of a packet is returned by `rd_data` when `rd_buf` is the buffer and `rd_idx` is the packet base plus k.
- R3: The occupancy of a buffer counts the words written to it and not yet popped. The flags are registered and change only after the clock edge that altered the occupancy:
  - `flag_empty` is set when occupancy is 0;
  - `flag_full` is set when occupancy equals DEPTH;
  - `flag_prog` is set when occupancy is at least `prog_lvl`.
  After reset every empty bit is 1 and every other flag is 0.
- R4: A packet-end strobe sampled on the same edge as an accepted write commits a packet that includes the word written on that edge.
- R5: A packet-end strobe sampled on an edge with no write commits every word written to that buffer since its last commit. With nothing pending, it commits a packet of length 0.
- R6: With `auto_en` high, an accepted write that brings the pending count of its buffer to `auto_len` commits a packet of exactly `auto_len` words.
- R7: A packet-end strobe on the same edge as an automatic commit produces no further packet. A strobe with a write one edge later commits a one-word packet.
- R8: A write to a buffer whose `flag_full` is set is dropped, and it sets that buffer's bit in `ovf`. An `ovf` bit stays set until reset.
- R9: Each value of `addr` selects its own buffer, with its own write position, pending count, occupancy and flags. Traffic to one buffer does not alter another.
- R10: A descriptor ({`cmt_len`, `cmt_buf`, `cmt_base`}) is presented while `cmt_valid` is high and is held unchanged until `cmt_ready` is high. Descriptors leave in commit order. Popping a descriptor lowers that buffer's occupancy by `cmt_len`.
- R11: While the descriptor queue holds QD entries, a packet-end strobe and a write that would complete an automatic packet are both refused, and each sets the buffer's `ovf` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| pktend_n | input | 1 | Packet-end strobe, active low |
| addr | input | AB | Buffer select |
| wdata | input | DW | Write data |
| auto_en | input | 1 | Enables automatic packet commit |
| auto_len | input | LW | Automatic packet length in words |
| prog_lvl | input | LW | Occupancy threshold for `flag_prog` |
| flag_empty | output | NB | Per-buffer empty flag |
| flag_full | output | NB | Per-buffer full flag |
| flag_prog | output | NB | Per-buffer programmable-level flag |
| ovf | output | NB | Per-buffer sticky overflow |
| cmt_valid | output | 1 | Descriptor available |
| cmt_ready | input | 1 | Consumer takes the descriptor |
| cmt_len | output | LW | Committed packet length |
| cmt_buf | output | AB | Buffer index of the packet |
| cmt_base | output | AW | Start position of the packet in its buffer |
| rd_buf | input | AB | Read port buffer select |
| rd_idx | input | AW | Read port position |
| rd_data | output | DW | Word at the read position |

## Verification
The assertions assume that `auto_len` and `prog_lvl` change only while no traffic is in flight, and that `auto_len` is never zero while `auto_en` is high. They also assume that the consumer pops only descriptors it has already seen. The bench changes those inputs only between scenarios, with the buses idle. It keeps `cmt_ready` low except during explicit pops, so a descriptor's hold behaviour is observed over several idle cycles. Full and overflow conditions are reached on purpose, but only through the normal write and strobe pins.

// File: rtl/slvf_pkg.sv
// Shared defaults and width helpers for the slave write FIFO.
// Assumes: callers derive every width from these helpers.
package slvf_pkg;
    localparam int DEF_NB    = 4;
    localparam int DEF_DEPTH = 16;
    localparam int DEF_DW    = 8;
    localparam int DEF_QD    = 4;

    // Bits needed to hold a count from 0 to n inclusive.
    function automatic int cnt_w(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/slvf_buf_ctrl.sv
// Per-buffer controller: write acceptance, write position, pending count,
// occupancy, commit decision and registered flags.
// Assumes: sel_wr/sel_end are already qualified by chip select and address;
// pop is only raised for a descriptor belonging to this buffer.
module slvf_buf_ctrl #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int LW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_wr,
    input  logic          sel_end,
    input  logic          auto_en,
    input  logic [LW-1:0] auto_len,
    input  logic [LW-1:0] prog_lvl,
    input  logic          cq_full,
    input  logic          pop,
    input  logic [LW-1:0] pop_len,
    output logic          wr_acc,
    output logic          push,
    output logic [LW-1:0] push_len,
    output logic [AW-1:0] push_base,
    output logic [AW-1:0] wptr,
    output logic          full,
    output logic          empty,
    output logic          prog,
    output logic          ovf
);
    logic [LW-1:0] occ_q, pend_q, occ_nxt;
    logic [AW-1:0] base_q, wptr_nxt;
    logic [LW:0]   pend_inc;
    logic          would_auto, auto_c, man_c, drop;

    // Decide acceptance, commit and next occupancy for this edge.
    always_comb begin
        pend_inc   = {1'b0, pend_q} + (LW+1)'(1);
        would_auto = auto_en && (pend_inc == {1'b0, auto_len});
        wr_acc     = sel_wr && !full && !(would_auto && cq_full);
        auto_c     = wr_acc && would_auto;
        man_c      = sel_end && !auto_c && !cq_full;
        push       = auto_c || man_c;
        push_len   = pend_q + LW'(wr_acc);
        push_base  = base_q;
        drop       = (sel_wr && !wr_acc) || (sel_end && !auto_c && cq_full);
        occ_nxt    = occ_q + LW'(wr_acc) - (pop ? pop_len : '0);
        wptr_nxt   = wptr + AW'(wr_acc);
    end

    // Register counters, packet base and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q  <= '0;
            pend_q <= '0;
            base_q <= '0;
            wptr   <= '0;
            full   <= 1'b0;
            empty  <= 1'b1;
            prog   <= 1'b0;
            ovf    <= 1'b0;
        end else begin
            occ_q  <= occ_nxt;
            pend_q <= push ? '0 : pend_q + LW'(wr_acc);
            wptr   <= wptr_nxt;
            if (push) base_q <= wptr_nxt;
            full   <= (occ_nxt == LW'(DEPTH));
            empty  <= (occ_nxt == '0);
            prog   <= (occ_nxt >= prog_lvl);
            if (drop) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/slvf_desc_q.sv
// Small first-in first-out queue of committed-packet descriptors.
// Assumes: push is never raised while full; QD is a power of two >= 2.
module slvf_desc_q #(
    parameter int W  = 11,
    parameter int QD = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         full,
    output logic         valid,
    output logic [W-1:0] dout
);
    localparam int PW = $clog2(QD);

    logic [W-1:0]  slot [QD];
    logic [PW-1:0] rd_q, wr_q;
    logic [PW:0]   cnt_q;
    logic          do_push, do_pop;

    // Occupancy view and effective transfers.
    always_comb begin
        full    = (cnt_q == (PW+1)'(QD));
        valid   = (cnt_q != '0);
        do_push = push && !full;
        do_pop  = pop && valid;
        dout    = slot[rd_q];
    end

    // Store descriptor payloads.
    always_ff @(posedge clk) begin
        if (do_push) slot[wr_q] <= din;
    end

    // Advance queue pointers and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + PW'(1);
            if (do_pop)  rd_q <= rd_q + PW'(1);
            cnt_q <= cnt_q + (PW+1)'(do_push) - (PW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/slave_pkt_fifo.sv
// Top of the slave write FIFO: decodes the bus strobes, instantiates one
// controller and storage array per buffer, and funnels commits into the
// descriptor queue.
// Assumes: NB is a power of two >= 2; DEPTH is a power of two; at most one
// buffer is addressed per edge, so at most one commit happens per edge.
module slave_pkt_fifo
    import slvf_pkg::*;
#(
    parameter int NB    = DEF_NB,
    parameter int DEPTH = DEF_DEPTH,
    parameter int DW    = DEF_DW,
    parameter int QD    = DEF_QD,
    localparam int AB   = $clog2(NB),
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = cnt_w(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic          pktend_n,
    input  logic [AB-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          auto_en,
    input  logic [LW-1:0] auto_len,
    input  logic [LW-1:0] prog_lvl,
    output logic [NB-1:0] flag_empty,
    output logic [NB-1:0] flag_full,
    output logic [NB-1:0] flag_prog,
    output logic [NB-1:0] ovf,
    output logic          cmt_valid,
    input  logic          cmt_ready,
    output logic [LW-1:0] cmt_len,
    output logic [AB-1:0] cmt_buf,
    output logic [AW-1:0] cmt_base,
    input  logic [AB-1:0] rd_buf,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    localparam int QW = AB + AW + LW;

    logic          wr_req, end_req, cq_full, q_push;
    logic [NB-1:0] wr_acc, push_v, pop_v;
    logic [LW-1:0] plen  [NB];
    logic [AW-1:0] pbase [NB];
    logic [AW-1:0] wptr  [NB];
    logic [DW-1:0] rd_b  [NB];
    logic [LW-1:0] q_len;
    logic [AB-1:0] q_buf;
    logic [AW-1:0] q_base;
    logic [QW-1:0] q_dout;

    // Qualify the bus strobes with chip select.
    always_comb begin
        wr_req  = !cs_n && !wr_n;
        end_req = !cs_n && !pktend_n;
    end

    for (genvar b = 0; b < NB; b++) begin : g_buf
        logic [DW-1:0] mem [DEPTH];

        assign pop_v[b] = cmt_valid && cmt_ready && (cmt_buf == AB'(b));

        slvf_buf_ctrl #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_ctrl (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_wr   (wr_req && (addr == AB'(b))),
            .sel_end  (end_req && (addr == AB'(b))),
            .auto_en  (auto_en),
            .auto_len (auto_len),
            .prog_lvl (prog_lvl),
            .cq_full  (cq_full),
            .pop      (pop_v[b]),
            .pop_len  (cmt_len),
            .wr_acc   (wr_acc[b]),
            .push     (push_v[b]),
            .push_len (plen[b]),
            .push_base(pbase[b]),
            .wptr     (wptr[b]),
            .full     (flag_full[b]),
            .empty    (flag_empty[b]),
            .prog     (flag_prog[b]),
            .ovf      (ovf[b])
        );

        // Store an accepted word at this buffer's write position.
        always_ff @(posedge clk) begin
            if (wr_acc[b]) mem[wptr[b]] <= wdata;
        end

        assign rd_b[b] = mem[rd_idx];
    end

    // Select the single committing buffer's descriptor.
    always_comb begin
        q_push = |push_v;
        q_len  = '0;
        q_buf  = '0;
        q_base = '0;
        for (int b = 0; b < NB; b++) begin
            if (push_v[b]) begin
                q_len  = plen[b];
                q_buf  = AB'(b);
                q_base = pbase[b];
            end
        end
    end

    slvf_desc_q #(.W(QW), .QD(QD)) u_descq (
        .clk  (clk),
        .rst_n(rst_n),
        .push (q_push),
        .din  ({q_buf, q_base, q_len}),
        .pop  (cmt_ready),
        .full (cq_full),
        .valid(cmt_valid),
        .dout (q_dout)
    );

    // Unpack the head descriptor and drive the read port.
    always_comb begin
        {cmt_buf, cmt_base, cmt_len} = q_dout;
        rd_data = rd_b[rd_buf];
    end
endmodule

// File: rtl/slave_pkt_fifo_chk.sv
// Checker for slave_pkt_fifo, attached by bind. Observes ports and the
// per-buffer accept/commit vectors.
// Assumes: auto_len is nonzero whenever auto_en is high.
module slave_pkt_fifo_chk #(
    parameter int NB    = 4,
    parameter int DEPTH = 16,
    parameter int AB    = 2,
    parameter int LW    = 5,
    parameter int AW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          wr_n,
    input logic          pktend_n,
    input logic [AB-1:0] addr,
    input logic          auto_en,
    input logic [LW-1:0] auto_len,
    input logic [NB-1:0] flag_full,
    input logic [NB-1:0] flag_empty,
    input logic [NB-1:0] ovf,
    input logic          cmt_valid,
    input logic          cmt_ready,
    input logic [LW-1:0] cmt_len,
    input logic [AB-1:0] cmt_buf,
    input logic [AW-1:0] cmt_base,
    input logic [NB-1:0] wr_acc,
    input logic [NB-1:0] push_v,
    input logic [LW-1:0] q_len
);
    assert_wr_qual_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_acc) |-> (!cs_n && !wr_n));

    assert_flag_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_full & flag_empty) == '0);

    assert_empty_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_empty & ~$past(flag_empty))) |-> $past(cmt_valid && cmt_ready));

    assert_auto_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|push_v) && !(!cs_n && !pktend_n)) |-> (auto_en && q_len == auto_len));

    assert_one_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push_v));

    assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && flag_full[addr]) |=> ovf[$past(addr)]);

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf & $past(ovf)) == $past(ovf));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && !cmt_ready) |=> (cmt_valid && $stable(cmt_len)
                                       && $stable(cmt_buf) && $stable(cmt_base)));

    assert_len_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |-> (cmt_len <= LW'(DEPTH)));
endmodule

bind slave_pkt_fifo slave_pkt_fifo_chk #(
    .NB(NB), .DEPTH(DEPTH), .AB(AB), .LW(LW), .AW(AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .pktend_n  (pktend_n),
    .addr      (addr),
    .auto_en   (auto_en),
    .auto_len  (auto_len),
    .flag_full (flag_full),
    .flag_empty(flag_empty),
    .ovf       (ovf),
    .cmt_valid (cmt_valid),
    .cmt_ready (cmt_ready),
    .cmt_len   (cmt_len),
    .cmt_buf   (cmt_buf),
    .cmt_base  (cmt_base),
    .wr_acc    (wr_acc),
    .push_v    (push_v),
    .q_len     (q_len)
);

// File: tb/slave_pkt_fifo_bench.sv
// Directed bench for slave_pkt_fifo: one task per scenario.
module slave_pkt_fifo_bench;
    localparam int NB = 4, DEPTH = 16, DW = 8, AB = 2, AW = 4, LW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, wr_n = 1'b1, pktend_n = 1'b1;
    logic [AB-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          auto_en = 1'b0;
    logic [LW-1:0] auto_len = LW'(3);
    logic [LW-1:0] prog_lvl = LW'(8);
    logic [NB-1:0] flag_empty, flag_full, flag_prog, ovf;
    logic          cmt_valid;
    logic          cmt_ready = 1'b0;
    logic [LW-1:0] cmt_len;
    logic [AB-1:0] cmt_buf;
    logic [AW-1:0] cmt_base;
    logic [AB-1:0] rd_buf = '0;
    logic [AW-1:0] rd_idx = '0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    slave_pkt_fifo u_slave_pkt_fifo (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .pktend_n(pktend_n),
        .addr(addr), .wdata(wdata), .auto_en(auto_en), .auto_len(auto_len),
        .prog_lvl(prog_lvl), .flag_empty(flag_empty), .flag_full(flag_full),
        .flag_prog(flag_prog), .ovf(ovf), .cmt_valid(cmt_valid),
        .cmt_ready(cmt_ready), .cmt_len(cmt_len), .cmt_buf(cmt_buf),
        .cmt_base(cmt_base), .rd_buf(rd_buf), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Drive one edge worth of bus inputs, then settle past the edge.
    task automatic cyc(input bit c, input bit w, input bit p,
                       input int a, input int d);
        cs_n = c; wr_n = w; pktend_n = p;
        addr = AB'(a); wdata = DW'(d);
        @(posedge clk); #1;
    endtask

    task automatic idle();
        cyc(1, 1, 1, 0, 0);
    endtask

    task automatic pop_chk(input string req, input int len, input int b, input int base);
        chk(req, "cmt_valid", 32'(cmt_valid), 1);
        chk(req, "cmt_len", 32'(cmt_len), 32'(len));
        chk(req, "cmt_buf", 32'(cmt_buf), 32'(b));
        chk(req, "cmt_base", 32'(cmt_base), 32'(base));
        cmt_ready = 1'b1;
        idle();
        cmt_ready = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int b, input int idx, input int exp);
        rd_buf = AB'(b); rd_idx = AW'(idx); #1;
        chk(req, "rd_data", 32'(rd_data), 32'(exp));
    endtask

    task automatic t_reset();
        chk("R3", "empty after reset", 32'(flag_empty), 32'hF);
        chk("R3", "full after reset", 32'(flag_full), 0);
        chk("R3", "prog after reset", 32'(flag_prog), 0);
        chk("R8", "ovf after reset", 32'(ovf), 0);
        chk("R10", "valid after reset", 32'(cmt_valid), 0);
    endtask

    task automatic t_qualify();
        cyc(1, 0, 1, 0, 8'h11);
        cyc(0, 1, 1, 0, 8'h12);
        cyc(1, 1, 0, 0, 0);
        idle();
        chk("R1", "no write without both strobes", 32'(flag_empty[0]), 1);
        chk("R1", "no commit without cs", 32'(cmt_valid), 0);
    endtask

    task automatic t_burst_same_edge();
        cyc(0, 0, 1, 0, 8'h20);
        chk("R3", "empty drops after first write", 32'(flag_empty[0]), 0);
        cyc(0, 0, 1, 0, 8'h21);
        cyc(0, 0, 1, 0, 8'h22);
        cyc(0, 0, 0, 0, 8'h23);
        idle();
        for (int i = 0; i < 4; i++) rd_chk("R2", 0, i, 8'h20 + i);
        pop_chk("R4", 4, 0, 0);
        chk("R3", "empty after pop", 32'(flag_empty[0]), 1);
    endtask

    task automatic t_late_strobe();
        cyc(0, 0, 1, 1, 8'h30);
        cyc(0, 0, 1, 1, 8'h31);
        idle();
        cyc(0, 1, 0, 1, 0);
        cyc(0, 1, 0, 1, 0);
        idle();
        pop_chk("R5", 2, 1, 0);
        pop_chk("R5", 0, 1, 2);
        chk("R5", "no extra descriptor", 32'(cmt_valid), 0);
    endtask

    task automatic t_auto();
        auto_en = 1'b1; auto_len = LW'(3);
        cyc(0, 0, 1, 2, 8'h60);
        cyc(0, 0, 1, 2, 8'h61);
        cyc(0, 0, 0, 2, 8'h62);
        cyc(0, 0, 0, 2, 8'h63);
        idle();
        pop_chk("R7", 3, 2, 0);
        pop_chk("R7", 1, 2, 3);
        chk("R7", "no stray one-word packet", 32'(cmt_valid), 0);
        rd_chk("R7", 2, 3, 8'h63);
        for (int i = 0; i < 6; i++) cyc(0, 0, 1, 2, 8'h70 + i);
        idle();
        pop_chk("R6", 3, 2, 4);
        pop_chk("R6", 3, 2, 7);
        chk("R6", "two auto packets only", 32'(cmt_valid), 0);
        auto_en = 1'b0;
    endtask

    task automatic t_full_overflow();
        for (int i = 0; i < 7; i++) cyc(0, 0, 1, 3, 8'h80 + i);
        chk("R3", "prog below level", 32'(flag_prog[3]), 0);
        cyc(0, 0, 1, 3, 8'h87);
        chk("R3", "prog at level", 32'(flag_prog[3]), 1);
        for (int i = 8; i < 16; i++) cyc(0, 0, 1, 3, 8'h80 + i);
        chk("R3", "full at depth", 32'(flag_full[3]), 1);
        cyc(0, 0, 1, 3, 8'hEE);
        chk("R8", "ovf set on dropped write", 32'(ovf), 32'h8);
        rd_chk("R8", 3, 0, 8'h80);
        cyc(0, 1, 0, 3, 0);
        idle();
        pop_chk("R8", 16, 3, 0);
        chk("R3", "empty after pop", 32'(flag_empty[3]), 1);
        chk("R8", "ovf sticky", 32'(ovf), 32'h8);
    endtask

    task automatic t_independent();
        cyc(0, 0, 1, 0, 8'h40);
        cyc(0, 0, 1, 1, 8'h50);
        cyc(0, 0, 1, 0, 8'h41);
        cyc(0, 0, 1, 1, 8'h51);
        cyc(0, 0, 1, 1, 8'h52);
        chk("R9", "untouched buffer stays empty", 32'(flag_empty[2]), 1);
        cyc(0, 1, 0, 0, 0);
        cyc(0, 1, 0, 1, 0);
        repeat (3) idle();
        chk("R10", "held valid", 32'(cmt_valid), 1);
        chk("R10", "held head buffer", 32'(cmt_buf), 0);
        rd_chk("R9", 0, 5, 8'h41);
        rd_chk("R9", 1, 4, 8'h52);
        pop_chk("R9", 2, 0, 4);
        pop_chk("R9", 3, 1, 2);
    endtask

    task automatic t_queue_full();
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 0);
        idle();
        chk("R11", "refused strobe sets ovf", 32'(ovf), 32'h9);
        for (int i = 0; i < 4; i++) pop_chk("R11", 0, 0, 6);
        chk("R11", "only queue depth committed", 32'(cmt_valid), 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle();
        t_reset();
        t_qualify();
        t_burst_same_edge();
        t_late_strobe();
        t_auto();
        t_full_overflow();
        t_independent();
        t_queue_full();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung expected completion");
            finish_run();
        end
    end
endmodule